// File: doc/BRIEF.md
# Prioritized Event Flag and Index Status Unit

This unit gathers three single-cycle event pulses from threshold comparators into sticky status flags. Software reads the flags as a group through a 32-bit register port and clears any subset by writing ones to the matching bit positions. The unit drives one interrupt line per flag. Each line is qualified by an enable input that is supplied from outside the unit.

A second register reports which pending event should be serviced first. Its value is the number of the lowest-numbered set flag, and 0 means nothing is pending. Reading this index register returns the index and, as a side effect, clears both the index and the flag it names. The next event can therefore be found with one read per event. While the debug input is high, reads of the index register have no side effects, so a debugger can inspect the unit without disturbing it.

Top module: `irq_prio_status`

## Requirements
- R1: An event pulse on `evt_pulse[i]` sets flag i, which holds until cleared. The flags read back at address 0x160 in bits 2:0 (bit i is flag i, which is event number i+1). Bits 31:3 of that address always read 0, and writing them has no effect.
- R2: A write to 0x160 clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R3: When an event pulse and a clear of the same flag happen in the same cycle, the flag ends up 1. The clear may come from a write of 1 or from an index read.
- R4: Address 0x164 reads the index in bits 3:0, with bits 31:4 reading 0. The index is 0 when no flag is set. Otherwise it is the lowest-numbered set event: flag bit 0 gives 1, bit 1 gives 2 and bit 2 gives 3. The index follows the flags with one cycle of delay.
- R5: A read of 0x164 with `emu_mode` low returns the index held before the read. If that index is non-zero, the read clears the named flag, the index reads 0 in the next cycle, and the index is recomputed from the remaining flags in the cycle after that.
- R6: A read of 0x164 with `emu_mode` high clears neither the index nor any flag.
- R7: Writes to 0x164 have no effect on the index or the flags.
- R8: `irq[i]` is high exactly when flag i and `irq_en[i]` are both high.
- R9: After reset all flags, the index and all interrupt lines are 0.
- R10: Reads of any address other than 0x160 and 0x164 return 0. `rdata` is 0 when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 3 | Event pulses, one per flag |
| irq_en | input | 3 | Per-flag interrupt enables |
| emu_mode | input | 1 | Debug access: suppresses the read side effect |
| addr | input | 12 | Register byte address |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| irq | output | 3 | Gated interrupt lines |

## Verification
The hardest case to reach is the collision between a clear and a new event on the same flag, especially when the clear comes from an index read. The stimulus first waits until the index names flag 0, then issues the index read in the same cycle as a fresh pulse on event 1, and reads the flags again afterwards. Back-to-back index reads check the one-cycle zero window and the recompute that follows. The emulation checks repeat the same read with `emu_mode` high and confirm that nothing changes.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;

    localparam int NUM_EVT   = 3;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int IDX_W     = 4;
    localparam logic [ADDR_W-1:0] FLAG_ADDR = 12'h160;
    localparam logic [ADDR_W-1:0] OFFS_ADDR = 12'h164;

    typedef logic [NUM_EVT-1:0] evt_vec_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_OFFS = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Lowest-numbered set flag wins; the result is 1-based and 0 means none.
    function automatic idx_t first_set(input evt_vec_t v);
        idx_t r;
        r = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (v[i]) r = idx_t'(i + 1);
        end
        return r;
    endfunction

    function automatic evt_vec_t idx_to_mask(input idx_t idx);
        evt_vec_t m;
        for (int i = 0; i < NUM_EVT; i++) begin
            m[i] = (idx == idx_t'(i + 1));
        end
        return m;
    endfunction

endpackage

// File: rtl/irqstat_decode.sv
module irqstat_decode
    import irqstat_pkg::*;
(
    input  bus_req_t          req,
    input  logic              emu_mode,
    input  evt_vec_t          flags,
    input  idx_t              offset,
    output evt_vec_t          w1c_mask,
    output logic              offs_rd_clr,
    output logic [DATA_W-1:0] rdata
);
    localparam int FLAG_PAD = DATA_W - NUM_EVT;
    localparam int IDX_PAD  = DATA_W - IDX_W;

    reg_sel_e sel;

    always_comb begin
        if (req.addr == FLAG_ADDR)      sel = SEL_FLAG;
        else if (req.addr == OFFS_ADDR) sel = SEL_OFFS;
        else                            sel = SEL_NONE;
    end

    // Only the low flag bits take part; the upper data bits are dropped.
    assign w1c_mask    = (req.wr && sel == SEL_FLAG) ? req.wdata[NUM_EVT-1:0] : '0;
    assign offs_rd_clr = req.rd && (sel == SEL_OFFS) && !emu_mode;

    always_comb begin
        rdata = '0;
        if (req.rd) begin
            unique case (sel)
                SEL_FLAG: rdata = {{FLAG_PAD{1'b0}}, flags};
                SEL_OFFS: rdata = {{IDX_PAD{1'b0}}, offset};
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqstat_flags.sv
module irqstat_flags
    import irqstat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t evt_pulse,
    input  evt_vec_t w1c_mask,
    input  evt_vec_t rd_clr_mask,
    output evt_vec_t flags
);
    evt_vec_t flags_q;

    generate
        for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)               flags_q[g] <= 1'b0;
                else if (evt_pulse[g]) flags_q[g] <= 1'b1;
                else if (w1c_mask[g] || rd_clr_mask[g]) flags_q[g] <= 1'b0;
            end

            // R3: a pulse always leaves the flag set
            a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
                evt_pulse[g] |=> flags_q[g]);

            // R2: a write-one clear without a racing pulse empties the flag
            a_r2_w1c_clears: assert property (@(posedge clk) disable iff (rst)
                (w1c_mask[g] && !evt_pulse[g]) |=> !flags_q[g]);

            // R1: a flag only drops when something cleared it
            a_r1_sticky: assert property (@(posedge clk) disable iff (rst)
                (flags_q[g] && !w1c_mask[g] && !rd_clr_mask[g]) |=> flags_q[g]);
        end
    endgenerate

    assign flags = flags_q;

endmodule

// File: rtl/irqstat_offset.sv
module irqstat_offset
    import irqstat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t flags,
    input  logic     rd_clr,
    output idx_t     offset,
    output evt_vec_t clr_mask
);
    idx_t offset_q;
    logic take;

    assign take     = rd_clr && (offset_q != '0);
    assign clr_mask = take ? idx_to_mask(offset_q) : '0;

    always_ff @(posedge clk) begin
        if (rst)       offset_q <= '0;
        else if (take) offset_q <= '0;
        else           offset_q <= first_set(flags);
    end

    assign offset = offset_q;

    // R4: the index never leaves the legal code range
    a_r4_index_range: assert property (@(posedge clk) disable iff (rst)
        offset_q <= idx_t'(NUM_EVT));

    // R5: a consuming read leaves the index at 0 for one cycle
    a_r5_read_zeroes: assert property (@(posedge clk) disable iff (rst)
        take |=> (offset_q == '0));

    // R5: a consuming read clears exactly one flag
    a_r5_one_flag: assert property (@(posedge clk) disable iff (rst)
        $countones(clr_mask) <= 1);

endmodule

// File: rtl/irq_prio_status.sv
module irq_prio_status
    import irqstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [NUM_EVT-1:0] irq_en,
    input  logic              emu_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_EVT-1:0] irq
);
    bus_req_t req;
    evt_vec_t flags;
    evt_vec_t w1c_mask;
    evt_vec_t rd_clr_mask;
    idx_t     offset;
    logic     offs_rd_clr;

    assign req = '{rd: rd_en, wr: wr_en, addr: addr, wdata: wdata};

    irqstat_decode u_decode (
        .req         (req),
        .emu_mode    (emu_mode),
        .flags       (flags),
        .offset      (offset),
        .w1c_mask    (w1c_mask),
        .offs_rd_clr (offs_rd_clr),
        .rdata       (rdata)
    );

    irqstat_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .evt_pulse   (evt_pulse),
        .w1c_mask    (w1c_mask),
        .rd_clr_mask (rd_clr_mask),
        .flags       (flags)
    );

    irqstat_offset u_offset (
        .clk      (clk),
        .rst      (rst),
        .flags    (flags),
        .rd_clr   (offs_rd_clr),
        .offset   (offset),
        .clr_mask (rd_clr_mask)
    );

    assign irq = flags & irq_en;

    // R6: a debug read of the index drops no flag
    a_r6_emu_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == OFFS_ADDR && emu_mode)
            |=> (($past(flags) & ~flags) == '0));

    // R7: a write to the index address drops no flag
    a_r7_offs_write_inert: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && addr == OFFS_ADDR) |=> (($past(flags) & ~flags) == '0));

    // R10: no read data without a read strobe
    a_r10_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0));

endmodule

// File: tb/irq_prio_status_bench.sv
module irq_prio_status_bench;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  evt_pulse = '0;
    logic [2:0]  irq_en = '0;
    logic        emu_mode = 1'b0;
    logic [11:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    rd_item_t exp_q[$];

    localparam logic [11:0] A_FLAG = 12'h160;
    localparam logic [11:0] A_OFFS = 12'h164;

    always #10 clk = ~clk;

    irq_prio_status u_irq_prio_status (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .irq_en(irq_en),
        .emu_mode(emu_mode), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Monitor: compares every read strobe against the next queued item.
    always @(negedge clk) begin
        if (rd_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: actual %h expected none", rdata);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic op(input logic rd, input logic wr, input logic [11:0] a,
                      input logic [31:0] wd, input logic [2:0] ev);
        @(posedge clk); #1;
        rd_en = rd; wr_en = wr; addr = a; wdata = wd; evt_pulse = ev;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag,
                      input logic [2:0] ev = 3'b000);
        exp_q.push_back('{exp: e, tag: tag});
        op(1'b1, 1'b0, a, '0, ev);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d,
                      input logic [2:0] ev = 3'b000);
        op(1'b0, 1'b1, a, d, ev);
    endtask

    task automatic pulse(input logic [2:0] ev);
        op(1'b0, 1'b0, '0, '0, ev);
    endtask

    task automatic idle();
        op(1'b0, 1'b0, '0, '0, 3'b000);
    endtask

    task automatic chk_irq(input logic [2:0] e, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, irq, e);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9: reset state
        chk_irq(3'b000, "R9 irq after reset");
        rd(A_FLAG, 32'h0, "R9 flags after reset");
        rd(A_OFFS, 32'h0, "R9 index after reset");

        // R1 / R4 / R5: capture, priority, consuming reads
        pulse(3'b110);
        idle();
        rd(A_FLAG, 32'h6, "R1 flags 6");
        rd(A_OFFS, 32'h2, "R4 index picks event 2");
        rd(A_OFFS, 32'h0, "R5 index zero after consume");
        rd(A_OFFS, 32'h3, "R5 index recomputed to 3");
        rd(A_FLAG, 32'h0, "R5 both flags consumed");

        // R6: debug reads have no side effect
        pulse(3'b100);
        idle();
        emu_mode = 1'b1;
        rd(A_OFFS, 32'h3, "R6 debug read index");
        rd(A_OFFS, 32'h3, "R6 index kept");
        rd(A_FLAG, 32'h4, "R6 flag kept");
        emu_mode = 1'b0;
        wr(A_FLAG, 32'h4);
        idle();

        // R2 / R1 / R7: write-one clear, upper bits, index writes
        pulse(3'b111);
        idle();
        wr(A_FLAG, 32'h2);
        rd(A_FLAG, 32'h5, "R2 clear only bit 1");
        wr(A_FLAG, 32'hFFFF_FFF8);
        rd(A_FLAG, 32'h5, "R1 upper bits ignored");
        wr(A_OFFS, 32'hF);
        idle();
        rd(A_OFFS, 32'h1, "R7 index unaffected by write");
        idle();
        rd(A_FLAG, 32'h4, "R5 read consumed flag 0");
        wr(A_FLAG, 32'h4);
        idle();
        rd(A_OFFS, 32'h0, "R4 nothing pending");

        // R3: set wins over both clear paths
        pulse(3'b001);
        wr(A_FLAG, 32'h1, 3'b001);
        rd(A_FLAG, 32'h1, "R3 pulse beats write clear");
        idle();
        rd(A_OFFS, 32'h1, "R3 index read during pulse", 3'b001);
        idle();
        rd(A_FLAG, 32'h1, "R3 pulse beats read clear");
        wr(A_FLAG, 32'h1);
        idle();

        // R8: interrupt gating
        irq_en = 3'b101;
        pulse(3'b111);
        idle();
        chk_irq(3'b101, "R8 gated by 101");
        irq_en = 3'b010;
        chk_irq(3'b010, "R8 gated by 010");
        wr(A_FLAG, 32'h7);
        idle();
        chk_irq(3'b000, "R8 cleared");

        // R10: unmapped addresses
        rd(12'h168, 32'h0, "R10 addr 168");
        rd(12'h000, 32'h0, "R10 addr 000");
        idle();
        idle();

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 reads left unanswered: actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule